// File: doc/BRIEF.md
# Transport Overhead Byte Insertion Selector

This block sits in the transmit path of a SONET/SDH framer, between the frame generator and the scrambler. For every byte the framer presents, together with its row and column position, it decides whether that byte goes out unchanged or is replaced. A replacement value comes from one of three sources: a programmable register value (S1 only), the byte delivered by a serial overhead access channel, or a global default pattern of all zeros or all ones.

Only the overhead bytes of the first STS-1 in the interleave are handled. The byte groups are E1, F1, the section data bytes D1–D3, the line data bytes D4–D12, S1, E2, and a "remaining" group made of J0, K1 and K2. Each group has its own active-high enable that selects the access-channel byte. All other bytes pass through.

The access channel supplies one byte plus one parity bit for each handled slot. The block checks that parity in odd or even mode, latches any error in a sticky status bit that software clears by writing one, and raises a maskable interrupt.

Top module: `toh_insert_sel`

## Requirements
- R1: Output is registered. `out_vld` equals `byte_vld` one clock later. `data_out` takes its new value one clock after a cycle with `byte_vld` high, and holds when `byte_vld` is low.
- R2: Columns are numbered from 1 and rows from 1 to 9. Overhead column k (1..3) of the first STS-1 is at `col_idx = 1 + (k-1)*STS_N`. The handled positions are:
  - E1 at row 2, k=2; F1 at row 2, k=3.
  - D1–D3 at row 3, k=1..3; D4–D12 at rows 6–8, k=1..3.
  - S1 at row 9, k=1; E2 at row 9, k=3.
  - The remaining group at row 1, k=3 and row 5, k=2..3.
- R3: At a handled position whose group enable is high, `data_out` is `acc_byte`. The S1 register enable must be low for this to apply at S1.
- R4: At a handled position whose group enable is low, `data_out` is 8'h00 when `dflt_ones` = 0 and 8'hFF when `dflt_ones` = 1.
- R5: At S1, `s1_reg_en` = 1 inserts `s1_reg_val` regardless of `en_s1`. Otherwise `en_s1` selects `acc_byte`, and with both low the default of R4 is used.
- R6: Every other byte passes through unchanged. This covers other STS-1 slots, row 4, A1/A2, B1/B2, M1 and columns beyond 3*STS_N.
- R7: At every handled position with `byte_vld` high, a parity error is detected when the number of ones in {`acc_byte`, `acc_par`} is even with `par_even` = 0 (odd parity), or odd with `par_even` = 1 (even parity). Group enables do not affect this check.
- R8: `par_err_sts` rises one clock after a detected error. It stays set until a cycle with `sts_clr` high and no new error. A new error in the same cycle as `sts_clr` keeps it set.
- R9: `par_irq` is high exactly when `par_err_sts` is high and `par_mask` is low.
- R10: During reset, `out_vld`, `data_out` and `par_err_sts` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Frame byte strobe |
| row_idx | input | 4 | Frame row, 1..9 |
| col_idx | input | COL_W | Frame column, from 1 |
| data_in | input | 8 | Byte from the frame generator |
| acc_byte | input | 8 | Access-channel byte for this slot |
| acc_par | input | 1 | Access-channel parity bit |
| en_e1 | input | 1 | Access value for E1 |
| en_f1 | input | 1 | Access value for F1 |
| en_dsec | input | 1 | Access value for D1–D3 |
| en_dline | input | 1 | Access value for D4–D12 |
| en_s1 | input | 1 | Access value for S1 |
| en_e2 | input | 1 | Access value for E2 |
| en_rest | input | 1 | Access value for J0, K1, K2 |
| dflt_ones | input | 1 | Default pattern: 0 = zeros, 1 = ones |
| s1_reg_en | input | 1 | Insert the register S1 value |
| s1_reg_val | input | 8 | Programmed S1 value |
| par_even | input | 1 | Parity mode: 0 = odd, 1 = even |
| par_mask | input | 1 | Interrupt mask |
| sts_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| data_out | output | 8 | Byte to the transmit path |
| out_vld | output | 1 | Strobe for data_out |
| par_err_sts | output | 1 | Sticky parity error status |
| par_irq | output | 1 | Parity error interrupt |

## Verification
The bench builds the block with STS_N = 3 and COL_W = 9. With these values the first STS-1's overhead columns are 1, 4 and 7. Columns 2, 3, 5, 6, 8 and 9 belong to other slots and must pass through, and columns 10 and up lie in the payload. This lets a single random sweep over rows 1–9 and columns 1–12 tell slot-1 substitution apart from interleaved neighbours and payload.

// File: rtl/toh_insert_sel.sv
module toh_insert_sel #(
  parameter int STS_N = 3,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [3:0]       row_idx,
  input  logic [COL_W-1:0] col_idx,
  input  logic [7:0]       data_in,
  input  logic [7:0]       acc_byte,
  input  logic             acc_par,
  input  logic             en_e1,
  input  logic             en_f1,
  input  logic             en_dsec,
  input  logic             en_dline,
  input  logic             en_s1,
  input  logic             en_e2,
  input  logic             en_rest,
  input  logic             dflt_ones,
  input  logic             s1_reg_en,
  input  logic [7:0]       s1_reg_val,
  input  logic             par_even,
  input  logic             par_mask,
  input  logic             sts_clr,
  output logic [7:0]       data_out,
  output logic             out_vld,
  output logic             par_err_sts,
  output logic             par_irq
);
  typedef enum logic [2:0] {
    G_NONE, G_E1, G_F1, G_DSEC, G_DLINE, G_S1, G_E2, G_REST
  } grp_t;

  logic [2:0] kcol;
  grp_t       grp;
  logic [7:0] dflt, sel;
  logic       par_bad;

  for (genvar k = 0; k < 3; k++) begin : g_kcol
    assign kcol[k] = (col_idx == COL_W'(1 + k * STS_N));
  end

  always_comb begin
    grp = G_NONE;
    case (row_idx)
      4'd1: if (kcol[2]) grp = G_REST;
      4'd2: if (kcol[1]) grp = G_E1; else if (kcol[2]) grp = G_F1;
      4'd3: if (|kcol) grp = G_DSEC;
      4'd5: if (kcol[1] || kcol[2]) grp = G_REST;
      4'd6, 4'd7, 4'd8: if (|kcol) grp = G_DLINE;
      4'd9: if (kcol[0]) grp = G_S1; else if (kcol[2]) grp = G_E2;
      default: grp = G_NONE;
    endcase
  end

  assign dflt = {8{dflt_ones}};

  always_comb begin
    case (grp)
      G_E1:    sel = en_e1    ? acc_byte : dflt;
      G_F1:    sel = en_f1    ? acc_byte : dflt;
      G_DSEC:  sel = en_dsec  ? acc_byte : dflt;
      G_DLINE: sel = en_dline ? acc_byte : dflt;
      G_S1:    sel = s1_reg_en ? s1_reg_val : (en_s1 ? acc_byte : dflt);
      G_E2:    sel = en_e2    ? acc_byte : dflt;
      G_REST:  sel = en_rest  ? acc_byte : dflt;
      default: sel = data_in;
    endcase
  end

  assign par_bad = byte_vld && (grp != G_NONE) && ((^{acc_byte, acc_par}) == par_even);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out    <= 8'h00;
      out_vld     <= 1'b0;
      par_err_sts <= 1'b0;
    end else begin
      out_vld     <= byte_vld;
      if (byte_vld) data_out <= sel;
      par_err_sts <= par_bad | (par_err_sts & ~sts_clr);
    end
  end

  assign par_irq = par_err_sts & ~par_mask;
endmodule

module toh_insert_sel_chk #(
  parameter int STS_N = 3,
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic [3:0]       row_idx,
  input logic [COL_W-1:0] col_idx,
  input logic [7:0]       data_in,
  input logic             en_e1,
  input logic             dflt_ones,
  input logic             s1_reg_en,
  input logic [7:0]       s1_reg_val,
  input logic             sts_clr,
  input logic [7:0]       data_out,
  input logic             out_vld,
  input logic             par_err_sts,
  input logic             par_irq
);
  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> out_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !out_vld);
  assert_e1_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && row_idx == 4'd2 && col_idx == COL_W'(1 + STS_N) && !en_e1)
      |=> data_out == {8{$past(dflt_ones)}});
  assert_s1_reg_prio_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && row_idx == 4'd9 && col_idx == COL_W'(1) && s1_reg_en)
      |=> data_out == $past(s1_reg_val));
  assert_payload_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && col_idx > COL_W'(3 * STS_N)) |=> data_out == $past(data_in));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_sts && !sts_clr) |=> par_err_sts);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !byte_vld) |=> !par_err_sts);
  assert_irq_needs_sts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_irq |-> par_err_sts);
endmodule

bind toh_insert_sel toh_insert_sel_chk #(.STS_N(STS_N), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .row_idx(row_idx),
  .col_idx(col_idx), .data_in(data_in), .en_e1(en_e1), .dflt_ones(dflt_ones),
  .s1_reg_en(s1_reg_en), .s1_reg_val(s1_reg_val), .sts_clr(sts_clr),
  .data_out(data_out), .out_vld(out_vld), .par_err_sts(par_err_sts),
  .par_irq(par_irq)
);

// File: tb/tb_toh_insert_sel.sv
module tb_toh_insert_sel;
  localparam int N = 3;
  localparam int CW = 9;

  logic clk = 1'b0, rst_n = 1'b0, byte_vld = 1'b0;
  logic [3:0] row_idx = '0;
  logic [CW-1:0] col_idx = '0;
  logic [7:0] data_in = '0, acc_byte = '0, s1_reg_val = '0;
  logic acc_par = 1'b0, en_e1 = 0, en_f1 = 0, en_dsec = 0, en_dline = 0;
  logic en_s1 = 0, en_e2 = 0, en_rest = 0, dflt_ones = 0, s1_reg_en = 0;
  logic par_even = 0, par_mask = 0, sts_clr = 0;
  logic [7:0] data_out;
  logic out_vld, par_err_sts, par_irq;

  int tests = 0, fails = 0;
  logic [7:0] exp_data = 8'h00;
  logic exp_sts = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  toh_insert_sel #(.STS_N(N), .COL_W(CW)) dut (.*);

  function automatic int grp_of(int r, int c);
    int k;
    k = (c == 1) ? 1 : (c == 1 + N) ? 2 : (c == 1 + 2 * N) ? 3 : 0;
    if (k == 0) return 0;
    if (r == 2 && k == 2) return 1;
    if (r == 2 && k == 3) return 2;
    if (r == 3) return 3;
    if (r >= 6 && r <= 8) return 4;
    if (r == 9 && k == 1) return 5;
    if (r == 9 && k == 3) return 6;
    if ((r == 1 && k == 3) || (r == 5 && k >= 2)) return 7;
    return 0;
  endfunction

  function automatic logic [7:0] model_byte();
    logic [7:0] d;
    logic en;
    d = {8{dflt_ones}};
    case (grp_of(int'(row_idx), int'(col_idx)))
      1: en = en_e1;
      2: en = en_f1;
      3: en = en_dsec;
      4: en = en_dline;
      5: begin
        if (s1_reg_en) return s1_reg_val;
        en = en_s1;
      end
      6: en = en_e2;
      7: en = en_rest;
      default: return data_in;
    endcase
    return en ? acc_byte : d;
  endfunction

  function automatic logic model_err();
    int ones;
    ones = $countones({acc_byte, acc_par});
    if (!byte_vld || grp_of(int'(row_idx), int'(col_idx)) == 0) return 1'b0;
    return par_even ? (ones % 2 == 1) : (ones % 2 == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    logic ev;
    ev = byte_vld;
    if (byte_vld) exp_data = model_byte();
    exp_sts = model_err() | (exp_sts & ~sts_clr);
    @(posedge clk);
    @(negedge clk);
    chk(out_vld == ev, "R1 out_vld", out_vld, ev);
    chk(data_out == exp_data, req, data_out, exp_data);
    chk(par_err_sts == exp_sts, "R7/R8 status", par_err_sts, exp_sts);
    chk(par_irq == (exp_sts & ~par_mask), "R9 irq", par_irq, exp_sts & ~par_mask);
  endtask

  task automatic put(input int r, input int c, input logic [7:0] d, input logic [7:0] a);
    byte_vld = 1'b1;
    row_idx = 4'(r);
    col_idx = CW'(c);
    data_in = d;
    acc_byte = a;
    acc_par = ~^a;
    sts_clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && data_out == 0 && par_err_sts == 0, "R10 reset", {out_vld, data_out, par_err_sts}, 0);
    rst_n = 1'b1;

    en_e1 = 1; put(2, 1 + N, 8'h3C, 8'hA5); step("R3 E1 access");
    en_e1 = 0; put(2, 1 + N, 8'h3C, 8'hA5); step("R4 E1 default zeros");
    dflt_ones = 1; put(3, 1 + 2 * N, 8'h11, 8'h22); step("R4 D3 default ones");
    en_dline = 1; put(8, 1, 8'h11, 8'h5A); step("R2 R3 D10 access");
    put(2, 2, 8'h77, 8'h5A); step("R6 other slot passthrough");
    put(4, 1, 8'h66, 8'h5A); step("R6 pointer row passthrough");
    put(5, 1, 8'h99, 8'h5A); step("R6 B2 passthrough");
    en_rest = 1; put(5, 1 + 2 * N, 8'h99, 8'hC3); step("R2 R3 K2 access");
    s1_reg_en = 1; en_s1 = 1; s1_reg_val = 8'h0F; put(9, 1, 8'h12, 8'hE1); step("R5 S1 register wins");
    s1_reg_en = 0; put(9, 1, 8'h12, 8'hE1); step("R5 S1 access");
    en_s1 = 0; dflt_ones = 0; put(9, 1, 8'h12, 8'hE1); step("R5 S1 default");
    byte_vld = 0; data_in = 8'hFF; step("R1 hold");

    par_even = 0; put(3, 1, 8'h01, 8'h03); acc_par = 0; step("R7 odd parity error");
    put(3, 1, 8'h01, 8'h03); step("R8 sticky");
    par_mask = 1; byte_vld = 0; step("R9 masked");
    par_mask = 0; byte_vld = 0; sts_clr = 1; step("R8 clear");
    par_even = 1; put(9, 1 + 2 * N, 8'h01, 8'h03); acc_par = 0; step("R7 even parity ok");
    put(9, 1 + 2 * N, 8'h01, 8'h03); acc_par = 1; step("R7 even parity error");
    put(9, 1 + 2 * N, 8'h01, 8'h03); acc_par = 1; sts_clr = 1; step("R8 set wins over clear");
    put(20, 50, 8'h01, 8'h03); row_idx = 4'd2; acc_par = 0; step("R6 R7 payload no check");

    for (int i = 0; i < 3000; i++) begin
      byte_vld = ($urandom % 8) != 0;
      row_idx = 4'(1 + $urandom % 9);
      col_idx = CW'(1 + $urandom % 12);
      data_in = 8'($urandom);
      acc_byte = 8'($urandom);
      acc_par = 1'($urandom);
      {en_e1, en_f1, en_dsec, en_dline, en_s1, en_e2, en_rest} = 7'($urandom);
      dflt_ones = 1'($urandom);
      s1_reg_en = 1'($urandom);
      s1_reg_val = 8'($urandom);
      par_even = 1'($urandom);
      par_mask = 1'($urandom);
      sts_clr = ($urandom % 4) == 0;
      step("R2 R3 R4 R5 R6 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule